// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is a port of general-purpose pins. Each pin has its own configuration bits: direction, output data, pull enable, polarity and interrupt enable. From these bits the block drives the pad controls: output value, output enable, pull-up enable and pull-down enable. Software reaches the registers through a simple write and read strobe bus. The read result appears on the cycle after the read strobe.

Pad inputs pass through a two-flop synchronizer. The block then watches each pin for one edge direction. The polarity bit picks that direction, and the same bit also picks which way an input pin is pulled. When a pin has its interrupt enable set and the chosen edge arrives, a sticky per-pin flag is set. Software clears a flag by writing 1 to its bit. Edge detection does not depend on direction, so a pin set as an output can trigger on the transitions it drives itself. One request line goes out for the whole port. It is high when any flag is set while its enable is set.

Top module: `gpio_edge_port`

## Requirements
- R1: When a pin's direction bit is 1, its output enable is 1 and its pad output equals its data bit. Neither its pull-up nor its pull-down is active, whatever pull enable says.
- R2: When a pin's direction bit is 0 and its pull enable is 1, polarity 0 activates the pull-up only and polarity 1 activates the pull-down only.
- R3: When a pin's direction bit is 0 and its pull enable is 0, neither its pull-up nor its pull-down is active.
- R4: With interrupt enable set, polarity 0 sets the pin's flag on a falling edge and polarity 1 on a rising edge. The opposite edge leaves the flag unchanged.
- R5: Edge detection also works on a pin configured as an output, so a transition the pin drives itself (looped back from the pad) sets its flag.
- R6: With interrupt enable clear, no edge sets the pin's flag and irq_o stays low, whatever the polarity.
- R7: A flag stays set until a write to the flag register (address 5) with a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R8: irq_o is high exactly when some pin has both its flag and its interrupt enable set. Clearing an enable drops the request while the flag stays set.
- R9: After reset, all configuration bits and flags are 0. Every pin is then an input with no pull, pad_oe_o is 0 and irq_o is 0.
- R10: A pad change reaches the flag and irq_o on the third rising clock edge after it, and not on the second.
- R11: Register map: 0 direction, 1 output data, 2 pull enable, 3 polarity, 4 interrupt enable, 5 flags, 6 synchronized pad input (read-only). A read strobe returns the addressed value on rdata_o after the next clock edge. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | N_PINS | Write data, one bit per pin |
| rdata_o | output | N_PINS | Registered read data |
| pad_i | input | N_PINS | Pad input values (asynchronous) |
| pad_o | output | N_PINS | Pad output values |
| pad_oe_o | output | N_PINS | Pad output enables |
| pull_up_o | output | N_PINS | Pull-up enables |
| pull_down_o | output | N_PINS | Pull-down enables |
| irq_o | output | 1 | Port interrupt request |

## Verification
The edge logic is tried in four settings:
- A full-port rising step and then a falling step, with half the pins on each polarity. This shows whether each pin picks its own edge and ignores the other.
- The same steps with enables cleared. This separates flag setting from plain edge detection.
- A loopback pattern in which a pin configured as an output toggles its own pad. This shows that detection does not depend on direction.
- A step sampled two and three edges later. This pins the synchronizer latency.

Partial flag clears, zero writes and enable removal with flags still set tell apart the sticky flag from the request masking.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_DIR     = 3'd0,
    REG_DOUT    = 3'd1,
    REG_PULL_EN = 3'd2,
    REG_POL     = 3'd3,
    REG_IRQ_EN  = 3'd4,
    REG_FLAG    = 3'd5,
    REG_PIN     = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stage1;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage1[i] <= 1'b0;
        sync_o[i] <= 1'b0;
      end else begin
        stage1[i] <= async_i[i];
        sync_o[i] <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] irq_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic hit;
    // polarity 1: rising, polarity 0: falling
    assign hit = irq_en_i[i] & (sync_i[i] ^ prev[i]) & (sync_i[i] == pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev[i]   <= 1'b0;
        flag_o[i] <= 1'b0;
      end else begin
        prev[i]   <= sync_i[i];
        // a new edge wins over a clear in the same cycle
        flag_o[i] <= hit | (flag_o[i] & ~clr_i[i]);
      end
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      pin_i,
  input  logic [N-1:0]      flag_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      dout_o,
  output logic [N-1:0]      pull_en_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      irq_en_o,
  output logic [N-1:0]      flag_clr_o
);
  logic [N-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o     <= '0;
      dout_o    <= '0;
      pull_en_o <= '0;
      pol_o     <= '0;
      irq_en_o  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_DIR:     dir_o     <= wdata_i;
        REG_DOUT:    dout_o    <= wdata_i;
        REG_PULL_EN: pull_en_o <= wdata_i;
        REG_POL:     pol_o     <= wdata_i;
        REG_IRQ_EN:  irq_en_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign flag_clr_o = (wr_en_i && addr_i == REG_FLAG) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_DIR:     rd_mux = dir_o;
      REG_DOUT:    rd_mux = dout_o;
      REG_PULL_EN: rd_mux = pull_en_o;
      REG_POL:     rd_mux = pol_o;
      REG_IRQ_EN:  rd_mux = irq_en_o;
      REG_FLAG:    rd_mux = flag_i;
      REG_PIN:     rd_mux = pin_i;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pull_up_o,
  output logic [N_PINS-1:0] pull_down_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] dir, dout, pull_en, pol, irq_en, flag_clr, flag, pin_sync;

  gpio_regs #(.N(N_PINS)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pin_i      (pin_sync),
    .flag_i     (flag),
    .rdata_o    (rdata_o),
    .dir_o      (dir),
    .dout_o     (dout),
    .pull_en_o  (pull_en),
    .pol_o      (pol),
    .irq_en_o   (irq_en),
    .flag_clr_o (flag_clr)
  );

  gpio_sync #(.N(N_PINS)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (pin_sync)
  );

  gpio_edge_det #(.N(N_PINS)) i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (pin_sync),
    .pol_i    (pol),
    .irq_en_i (irq_en),
    .clr_i    (flag_clr),
    .flag_o   (flag)
  );

  assign pad_o       = dout;
  assign pad_oe_o    = dir;
  assign pull_up_o   = ~dir & pull_en & ~pol;
  assign pull_down_o = ~dir & pull_en & pol;
  assign irq_o       = |(flag & irq_en);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      pad_oe_o,
  input logic [N-1:0]      pull_up_o,
  input logic [N-1:0]      pull_down_o,
  input logic              irq_o,
  input logic [N-1:0]      flag,
  input logic [N-1:0]      irq_en
);
  logic [N-1:0] clr_mask;
  assign clr_mask = (wr_en_i && addr_i == REG_FLAG) ? wdata_i : '0;

  a_r1_out_no_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & (pull_up_o | pull_down_o)) == '0);

  a_r2_one_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & pull_down_o) == '0);

  a_r6_flag_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag & ~$past(flag) & ~$past(irq_en)) == '0);

  a_r7_w1c_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag) & ~flag & ~$past(clr_mask)) == '0);

  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (flag != '0));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.N(N_PINS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .pad_oe_o    (pad_oe_o),
  .pull_up_o   (pull_up_o),
  .pull_down_o (pull_down_o),
  .irq_o       (irq_o),
  .flag        (flag),
  .irq_en      (irq_en)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0, ext = '0;
  logic [N-1:0] rdata, pad_in, pad_out, pad_oe, pu, pd;
  logic         irq;
  int           n_chk = 0, n_fail = 0;
  logic         rd_seen = 1'b0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  bit           done = 1'b0;

  always #2 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_edge_port #(.N_PINS(N)) i_gpio_edge_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .pull_up_o(pu), .pull_down_o(pd),
    .irq_o(irq)
  );

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: queue the expected read value, then strobe
  task automatic rd(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare each read result as it appears
  initial forever begin
    @(negedge clk);
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(rdata, 'x, "R11 unexpected read");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R9 reset state
    chk(pad_oe, 8'h00, "R9 oe"); chk(pad_out, 8'h00, "R9 out");
    chk(pu | pd, 8'h00, "R9 pulls"); chk({7'b0, irq}, 8'h00, "R9 irq");
    for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R9 reg zero");

    // R2 pull selection by polarity
    wr(3'd2, 8'hFF); wr(3'd3, 8'hF0);
    chk(pu, 8'h0F, "R2 pull-up"); chk(pd, 8'hF0, "R2 pull-down");
    // R1 outputs override pulls
    wr(3'd0, 8'h81); wr(3'd1, 8'h01);
    chk(pad_oe, 8'h81, "R1 oe"); chk(pad_out, 8'h01, "R1 out");
    chk(pu, 8'h0E, "R1 pull-up masked"); chk(pd, 8'h70, "R1 pull-down masked");
    // R3 no pull without enable
    wr(3'd2, 8'h00);
    chk(pu | pd, 8'h00, "R3 no pull");
    // R11 read back
    rd(3'd0, 8'h81, "R11 dir"); rd(3'd1, 8'h01, "R11 dout");
    rd(3'd3, 8'hF0, "R11 pol"); rd(3'd7, 8'h00, "R11 unused addr");
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);

    // R4 / R10 rising step
    wr(3'd4, 8'hFF);
    step(4);
    rd(3'd5, 8'h00, "R4 no flag idle");
    ext = 8'hFF;
    step(2);
    chk({7'b0, irq}, 8'h00, "R10 not at 2nd edge");
    step(1);
    chk({7'b0, irq}, 8'h01, "R10 at 3rd edge");
    rd(3'd5, 8'hF0, "R4 rising only on pol1");
    ext = 8'h00;
    step(4);
    rd(3'd5, 8'hFF, "R4 falling on pol0");

    // R7 write-one-to-clear
    wr(3'd5, 8'h0F);
    rd(3'd5, 8'hF0, "R7 partial clear");
    wr(3'd5, 8'h00);
    rd(3'd5, 8'hF0, "R7 zero write ignored");
    // R8 request masking
    wr(3'd4, 8'h0F);
    chk({7'b0, irq}, 8'h00, "R8 irq masked");
    rd(3'd5, 8'hF0, "R8 flags kept");
    wr(3'd5, 8'hFF);
    rd(3'd5, 8'h00, "R7 full clear");

    // R6 disabled pins ignore edges
    ext = 8'hF0;
    step(4);
    ext = 8'h00;
    step(4);
    rd(3'd5, 8'h00, "R6 no flag");
    chk({7'b0, irq}, 8'h00, "R6 irq low");

    // R5 output pin triggers on its own falling edge
    wr(3'd3, 8'h00); wr(3'd4, 8'h01); wr(3'd0, 8'h01);
    wr(3'd1, 8'h01);
    step(4);
    rd(3'd5, 8'h00, "R5 rising ignored on pol0");
    wr(3'd1, 8'h00);
    step(3);
    chk({7'b0, irq}, 8'h01, "R5 irq from own edge");
    rd(3'd5, 8'h01, "R5 flag");

    // R11 synchronized pin input
    ext = 8'hA5;
    step(3);
    rd(3'd6, 8'hA4, "R11 pin input");

    step(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule